// File: doc/BRIEF.md
# Three-Register Dedicated-Multiplexer Transfer Network

This block holds three data registers. Each one is fed by a multiplexer of its own that picks between the other two registers. Each register has a private select bit and a private load bit. Every register whose load bit is set captures its chosen source on the same clock edge. Because no source path is shared, any mix of transfers can happen in one cycle, including swaps, rotations and one value fanned out to two destinations.

A separate initialisation port writes one register directly: a strobe, a 2-bit register index and a data word. The write lands on the next clock edge and overrides all load bits for that cycle. The three register values come out as observation ports.

Reset is asynchronous and active-low. It clears all registers at once, and its release passes through a two-stage synchroniser before loads take effect.

Top module: `xfer_net`

## Requirements
- R1: While rst_n is low all three outputs read zero, independent of the clock, and no load or init write takes effect; after rst_n rises, writes take effect from the third rising edge on.
- R2: A register whose load bit (load[0] for r0, load[1] for r1, load[2] for r2) is 0 keeps its value whatever its select bit is, as long as init_en is low.
- R3: When load[2]=1, r2 takes r0 if sel[2]=0 and takes r1 if sel[2]=1.
- R4: When load[1]=1, r1 takes r0 if sel[1]=0 and takes r2 if sel[1]=1.
- R5: When load[0]=1, r0 takes r1 if sel[0]=0 and takes r2 if sel[0]=1.
- R6: All sources are sampled before the edge, so loads in one cycle see the old values: a swap exchanges two registers, and one source may feed two destinations.
- R7: With init_en=1, the register numbered by init_idx (0, 1 or 2) takes init_data on the next rising edge.
- R8: While init_en=1 every load bit is ignored; with init_idx=3 no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Per-register source select, bit i for register i |
| load | input | 3 | Per-register load enable, bit i for register i |
| init_en | input | 1 | Direct-write strobe, active high |
| init_idx | input | 2 | Register written by the strobe (3 = none) |
| init_data | input | WIDTH | Value written by the strobe |
| r0_q | output | WIDTH | Register 0 contents |
| r1_q | output | WIDTH | Register 1 contents |
| r2_q | output | WIDTH | Register 2 contents |

## Verification
The bench builds the block with WIDTH=8. Before each table vector it presets the registers to three distinct byte values, so every output byte shows which source it came from. With this preset, a wrong multiplexer leg, a missed simultaneous load, or a value taken after the edge instead of before it all show up as a wrong byte. Directed steps then cover hold under reset, the out-of-range init index, init overriding active loads, a two-cycle chain, and an asynchronous clear in the middle of a run.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int NREG = 3;
  localparam int IDXW = 2;

  typedef enum logic [IDXW-1:0] {
    IDX_R0   = 2'd0,
    IDX_R1   = 2'd1,
    IDX_R2   = 2'd2,
    IDX_NONE = 2'd3
  } reg_idx_e;

  // Source taken when the register's select bit is 0.
  function automatic int src_when_low(input int dst);
    return (dst == 0) ? 1 : 0;
  endfunction

  // Source taken when the register's select bit is 1.
  function automatic int src_when_high(input int dst);
    return (dst == 2) ? 1 : 2;
  endfunction
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_q = chain[STAGES-1];
endmodule

// File: rtl/xfer_src_mux.sv
module xfer_src_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] src_lo,
  input  logic [WIDTH-1:0] src_hi,
  input  logic             pick,
  output logic [WIDTH-1:0] src_out
);
  always_comb begin
    if (pick) src_out = src_hi;
    else      src_out = src_lo;
  end
endmodule

// File: rtl/xfer_reg_slice.sv
module xfer_reg_slice #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             init_en,
  input  logic             init_hit,
  input  logic [WIDTH-1:0] init_data,
  input  logic [WIDTH-1:0] mux_src,
  output logic [WIDTH-1:0] q
);
  logic             cen;
  logic [WIDTH-1:0] nxt;

  // Next-state: the direct write wins over the multiplexer path.
  always_comb begin
    if (init_en) begin
      cen = init_hit;
      nxt = init_data;
    end else begin
      cen = load;
      nxt = mux_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (cen) begin
      q <= nxt;
    end
  end
endmodule

// File: rtl/xfer_net.sv
module xfer_net
  import xfer_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int RST_STAGE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREG-1:0]     sel,
  input  logic [NREG-1:0]     load,
  input  logic                init_en,
  input  logic [IDXW-1:0]     init_idx,
  input  logic [WIDTH-1:0]    init_data,
  output logic [WIDTH-1:0]    r0_q,
  output logic [WIDTH-1:0]    r1_q,
  output logic [WIDTH-1:0]    r2_q
);
  logic             rst_n_q;
  logic [WIDTH-1:0] regs [NREG];
  logic [WIDTH-1:0] srcs [NREG];

  xfer_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_q (rst_n_q)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam int LO = src_when_low(i);
    localparam int HI = src_when_high(i);

    xfer_src_mux #(.WIDTH(WIDTH)) u_mux (
      .src_lo  (regs[LO]),
      .src_hi  (regs[HI]),
      .pick    (sel[i]),
      .src_out (srcs[i])
    );

    xfer_reg_slice #(.WIDTH(WIDTH)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n_q),
      .load      (load[i]),
      .init_en   (init_en),
      .init_hit  (init_idx == IDXW'(i)),
      .init_data (init_data),
      .mux_src   (srcs[i]),
      .q         (regs[i])
    );
  end

  assign r0_q = regs[0];
  assign r1_q = regs[1];
  assign r2_q = regs[2];
endmodule

// File: rtl/xfer_net_chk.sv
module xfer_net_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_q,
  input logic [2:0]       sel,
  input logic [2:0]       load,
  input logic             init_en,
  input logic [1:0]       init_idx,
  input logic [WIDTH-1:0] init_data,
  input logic [WIDTH-1:0] r0_q,
  input logic [WIDTH-1:0] r1_q,
  input logic [WIDTH-1:0] r2_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_q |-> (r0_q == '0 && r1_q == '0 && r2_q == '0)); // R1
  AST_R0_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (!init_en && !load[0]) |=> $stable(r0_q)); // R2
  AST_R1_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (!init_en && !load[1]) |=> $stable(r1_q)); // R2
  AST_R2_FROM_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (!init_en && load[2] && sel[2]) |=> (r2_q == $past(r1_q))); // R3
  AST_R2_FROM_R0: assert property (@(posedge clk) disable iff (!rst_q)
    (!init_en && load[2] && !sel[2]) |=> (r2_q == $past(r0_q))); // R3
  AST_R1_FROM_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (!init_en && load[1] && sel[1]) |=> (r1_q == $past(r2_q))); // R4
  AST_R0_FROM_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (!init_en && load[0] && sel[0]) |=> (r0_q == $past(r2_q))); // R5
  AST_SWAP_OLD: assert property (@(posedge clk) disable iff (!rst_q)
    (!init_en && load[0] && load[1] && !sel[0] && !sel[1])
      |=> (r0_q == $past(r1_q) && r1_q == $past(r0_q))); // R6
  AST_INIT_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    (init_en && init_idx == 2'd1) |=> (r1_q == $past(init_data))); // R7
  AST_INIT_NONE: assert property (@(posedge clk) disable iff (!rst_q)
    (init_en && init_idx == 2'd3)
      |=> ($stable(r0_q) && $stable(r1_q) && $stable(r2_q))); // R8
endmodule

bind xfer_net xfer_net_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_q     (rst_n_q),
  .sel       (sel),
  .load      (load),
  .init_en   (init_en),
  .init_idx  (init_idx),
  .init_data (init_data),
  .r0_q      (r0_q),
  .r1_q      (r1_q),
  .r2_q      (r2_q)
);

// File: tb/xfer_net_tb.sv
module xfer_net_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 10;

  // Vector layout: {sel[2:0], load[2:0], exp_r0, exp_r1, exp_r2}
  // Every vector starts from r0=11, r1=22, r2=33.
  localparam logic [29:0] VEC [NVEC] = '{
    {3'b100, 3'b100, 8'h11, 8'h22, 8'h22}, // R3 r2<-r1
    {3'b001, 3'b110, 8'h11, 8'h11, 8'h11}, // R6 r0 fans out to r1,r2
    {3'b111, 3'b000, 8'h11, 8'h22, 8'h33}, // R2 no loads
    {3'b000, 3'b011, 8'h22, 8'h11, 8'h33}, // R6 swap r0,r1
    {3'b000, 3'b111, 8'h22, 8'h11, 8'h11}, // R3 R4 R5 low legs
    {3'b111, 3'b111, 8'h33, 8'h33, 8'h22}, // R3 R4 R5 high legs
    {3'b010, 3'b111, 8'h22, 8'h33, 8'h11}, // R6 rotation
    {3'b001, 3'b001, 8'h33, 8'h22, 8'h33}, // R5 r0<-r2
    {3'b010, 3'b010, 8'h11, 8'h33, 8'h33}, // R4 r1<-r2
    {3'b011, 3'b100, 8'h11, 8'h22, 8'h11}  // R3 r2<-r0
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   sel;
  logic [2:0]   load;
  logic         init_en;
  logic [1:0]   init_idx;
  logic [W-1:0] init_data;
  logic [W-1:0] r0_q, r1_q, r2_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  xfer_net #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .load(load),
    .init_en(init_en), .init_idx(init_idx), .init_data(init_data),
    .r0_q(r0_q), .r1_q(r1_q), .r2_q(r2_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check3(input string tag, input logic [W-1:0] e0,
                        input logic [W-1:0] e1, input logic [W-1:0] e2);
    check({tag, " r0"}, r0_q, e0);
    check({tag, " r1"}, r1_q, e1);
    check({tag, " r2"}, r2_q, e2);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [2:0] s, input logic [2:0] l,
                      input logic ie, input logic [1:0] ix,
                      input logic [W-1:0] d);
    sel = s; load = l; init_en = ie; init_idx = ix; init_data = d;
    @(posedge clk);
    @(negedge clk);
    load = 3'b000; init_en = 1'b0;
  endtask

  task automatic preset();
    step(3'b000, 3'b000, 1'b1, 2'd0, 8'h11);
    step(3'b000, 3'b000, 1'b1, 2'd1, 8'h22);
    step(3'b000, 3'b000, 1'b1, 2'd2, 8'h33);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = '0; load = '0; init_en = 1'b0;
    init_idx = '0; init_data = '0;
    repeat (3) @(negedge clk);
    check3("R1 reset state", 8'h00, 8'h00, 8'h00);
    step(3'b000, 3'b111, 1'b1, 2'd0, 8'h55);
    check3("R1 write blocked in reset", 8'h00, 8'h00, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check3("R1 after release", 8'h00, 8'h00, 8'h00);

    preset();
    check3("R7 init each index", 8'h11, 8'h22, 8'h33);

    for (int i = 0; i < NVEC; i++) begin
      preset();
      step(VEC[i][29:27], VEC[i][26:24], 1'b0, 2'd0, 8'h00);
      check3($sformatf("R2-R6 vector %0d", i),
             VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    preset();
    step(3'b000, 3'b111, 1'b1, 2'd3, 8'hAA);
    check3("R8 index 3 writes nothing", 8'h11, 8'h22, 8'h33);

    preset();
    step(3'b111, 3'b111, 1'b1, 2'd1, 8'h5A);
    check3("R8 init overrides loads", 8'h11, 8'h5A, 8'h33);

    preset();
    step(3'b000, 3'b011, 1'b0, 2'd0, 8'h00);
    step(3'b000, 3'b100, 1'b0, 2'd0, 8'h00);
    check3("R6 two-cycle chain", 8'h22, 8'h11, 8'h22);

    rst_n = 1'b0;
    #1;
    check3("R1 async clear mid-run", 8'h00, 8'h00, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule